// File: doc/BRIEF.md
# Interleaved Stream Reduction Unit

This block folds a stream of W-bit integer elements into a single value with either addition or multiplication. Both operations are associative and commutative, so the unit spreads consecutive elements over K independent partial accumulators. Each element is combined with its accumulator through a pipelined operator that takes L cycles and accepts a new operation every cycle. A single accumulator would form one dependency chain and could take only one element every L cycles. With K of them, up to K operations are in flight, and when K is at least L the stream is taken at one element per cycle.

A producer offers elements with a valid/ready handshake and flags the end of the stream with a last marker. The marker may travel with the final element or arrive alone with no data. A marker alone with no elements before it gives an empty stream. The operation is chosen at the first beat of each stream. When the stream closes, the unit lets the in-flight operations drain. It then merges the partial results one after another through the same operator and presents the total on a one-cycle result strobe. All arithmetic wraps modulo 2^W.

Top module: `redu_top`

## Requirements
- R1: Once reset is released, `res_valid` is low and `in_ready` is high.
- R2: With `in_op` = 0 (add), the result equals the sum of all accepted elements modulo 2^W.
- R3: With `in_op` = 1 (multiply), the result equals the product of all accepted elements modulo 2^W, truncated to the low W bits.
- R4: Element number i of a stream, counted from 0, is folded into accumulator i mod K. No operation is ever issued to an accumulator whose previous operation is still in flight. With the default K = L = 3, an element offered on every cycle is accepted on every cycle and `in_ready` never drops during the stream.
- R5: An empty stream gives the identity of the selected operation: 0 for add, 1 for multiply.
- R6: `in_op` is sampled on the first beat of a stream. Changes on later beats of the same stream have no effect on the result.
- R7: `res_valid` is high for exactly one cycle per stream. `in_ready` is low from the cycle after the last-marker beat until the result strobe.
- R8: The result strobe appears only after every in-flight operation has left the operator pipeline.
- R9: A beat where `in_last` = 1 and `in_valid` = 0 ends the stream and adds no element. Once a result is given, all accumulators return to the identity, so the next stream's result does not depend on earlier streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An element is present on `in_data` |
| in_ready | output | 1 | The unit takes the current beat at the clock edge |
| in_data | input | W | Element value |
| in_last | input | 1 | This beat ends the stream (with or without an element) |
| in_op | input | 1 | Operation: 0 add, 1 multiply; sampled on the first beat |
| res_valid | output | 1 | One-cycle strobe: `res_data` holds the stream result |
| res_data | output | W | Reduced value |

## Verification
A wrong accumulator state shows up only in the final result. The bench therefore compares every strobe against a model fold. Streams of lengths 0, 1, K-1, K, K+1 and longer are used, so that leftover elements and unused accumulators are both exercised. A lost forward from the returning pipeline stage shows up in one of two ways: a wrong total several cycles after the last marker, or an unexpected drop of `in_ready` during a back-to-back stream, which the bench counts. A stale operation latch or a missed accumulator clear shows up in the stream that follows, as its result includes the earlier data or uses the earlier operation.

// File: rtl/redu_pkg.sv
package redu_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } redu_op_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_MERGE = 2'd2
    } redu_state_e;

endpackage

// File: rtl/redu_op_pipe.sv
// Pipelined combine operator: accepts one operation per cycle and
// returns it L cycles later together with its accumulator tag.
module redu_op_pipe
    import redu_pkg::*;
#(
    parameter int W  = 32,
    parameter int L  = 3,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  redu_op_e      issue_op,
    input  logic [W-1:0]  issue_a,
    input  logic [W-1:0]  issue_b,
    input  logic [TW-1:0] issue_tag,
    output logic          ret_valid,
    output logic [TW-1:0] ret_tag,
    output logic [W-1:0]  ret_data,
    output logic          empty
);

    typedef struct packed {
        logic          v;
        logic [TW-1:0] t;
        logic [W-1:0]  d;
    } stage_t;

    stage_t [L-1:0] pipe_d, pipe_q;
    logic [W-1:0]   comb_res;

    always_comb begin
        if (issue_op == OP_MUL) begin
            comb_res = issue_a * issue_b;
        end else begin
            comb_res = issue_a + issue_b;
        end

        pipe_d[0].v = issue_valid;
        pipe_d[0].t = issue_tag;
        pipe_d[0].d = comb_res;
        for (int i = 1; i < L; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end

        empty = 1'b1;
        for (int i = 0; i < L; i++) begin
            if (pipe_q[i].v) begin
                empty = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign ret_valid = pipe_q[L-1].v;
    assign ret_tag   = pipe_q[L-1].t;
    assign ret_data  = pipe_q[L-1].d;

endmodule

// File: rtl/redu_acc_bank.sv
// K partial accumulators with per-slot "holds data" and "in flight" flags.
module redu_acc_bank #(
    parameter int W  = 32,
    parameter int K  = 3,
    parameter int TW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic [TW-1:0]       wr_slot,
    input  logic [W-1:0]        wr_data,
    input  logic                claim_en,
    input  logic [TW-1:0]       claim_slot,
    output logic [K-1:0][W-1:0] acc_o,
    output logic [K-1:0]        used_o,
    output logic [K-1:0]        busy_o
);

    typedef struct packed {
        logic [K-1:0][W-1:0] acc;
        logic [K-1:0]        used;
        logic [K-1:0]        busy;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr) begin
            bank_d.used = '0;
        end
        if (wr_en) begin
            bank_d.acc[wr_slot]  = wr_data;
            bank_d.used[wr_slot] = 1'b1;
            bank_d.busy[wr_slot] = 1'b0;
        end
        // a new claim wins over the release of the same slot
        if (claim_en) begin
            bank_d.busy[claim_slot] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign acc_o  = bank_q.acc;
    assign used_o = bank_q.used;
    assign busy_o = bank_q.busy;

endmodule

// File: rtl/redu_top.sv
module redu_top
    import redu_pkg::*;
#(
    parameter int W = 32,
    parameter int K = 3,
    parameter int L = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         in_last,
    input  logic         in_op,
    output logic         res_valid,
    output logic [W-1:0] res_data
);

    localparam int TW = (K > 1) ? $clog2(K) : 1;
    localparam int CW = $clog2(K + 1);

    typedef struct packed {
        redu_state_e   st;
        logic [TW-1:0] slot;
        logic          open;
        redu_op_e      op;
        logic [CW-1:0] mcnt;
        logic          res_v;
        logic [W-1:0]  res_d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                issue_v;
    logic [W-1:0]        issue_a;
    logic [W-1:0]        issue_b;
    logic [TW-1:0]       issue_tag;
    redu_op_e            cur_op;
    logic                ret_valid;
    logic [TW-1:0]       ret_tag;
    logic [W-1:0]        ret_data;
    logic                pipe_empty;
    logic                bank_clr;
    logic [K-1:0][W-1:0] acc;
    logic [K-1:0]        used;
    logic [K-1:0]        busy;
    logic [K-1:0]        hit;
    logic [K-1:0]        avail;
    logic [K-1:0][W-1:0] fwd;
    logic [W-1:0]        ident;
    logic                beat;

    redu_op_pipe #(.W(W), .L(L), .TW(TW)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_v),
        .issue_op    (cur_op),
        .issue_a     (issue_a),
        .issue_b     (issue_b),
        .issue_tag   (issue_tag),
        .ret_valid   (ret_valid),
        .ret_tag     (ret_tag),
        .ret_data    (ret_data),
        .empty       (pipe_empty)
    );

    redu_acc_bank #(.W(W), .K(K), .TW(TW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (bank_clr),
        .wr_en      (ret_valid),
        .wr_slot    (ret_tag),
        .wr_data    (ret_data),
        .claim_en   (issue_v),
        .claim_slot (issue_tag),
        .acc_o      (acc),
        .used_o     (used),
        .busy_o     (busy)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.res_v = 1'b0;

        cur_op = ctl_q.open ? ctl_q.op : redu_op_e'(in_op);
        ident  = {{(W-1){1'b0}}, (cur_op == OP_MUL)};

        // operand view per slot: returning value, stored value or identity
        for (int s = 0; s < K; s++) begin
            hit[s]   = ret_valid && (ret_tag == TW'(s));
            avail[s] = !busy[s] || hit[s];
            if (hit[s]) begin
                fwd[s] = ret_data;
            end else if (used[s]) begin
                fwd[s] = acc[s];
            end else begin
                fwd[s] = ident;
            end
        end

        issue_v   = 1'b0;
        issue_a   = '0;
        issue_b   = '0;
        issue_tag = '0;
        bank_clr  = 1'b0;

        in_ready = (ctl_q.st == ST_RUN) && avail[ctl_q.slot];
        beat     = in_ready && (in_valid || in_last);

        case (ctl_q.st)
            ST_RUN: begin
                if (beat) begin
                    ctl_d.open = 1'b1;
                    ctl_d.op   = cur_op;
                    if (in_valid) begin
                        issue_v   = 1'b1;
                        issue_a   = fwd[ctl_q.slot];
                        issue_b   = in_data;
                        issue_tag = ctl_q.slot;
                        ctl_d.slot = (ctl_q.slot == TW'(K - 1)) ? '0
                                                                 : ctl_q.slot + TW'(1);
                    end
                    if (in_last) begin
                        ctl_d.st   = ST_DRAIN;
                        ctl_d.slot = '0;
                    end
                end
            end
            ST_DRAIN: begin
                if (busy == '0) begin
                    ctl_d.st   = ST_MERGE;
                    ctl_d.mcnt = CW'(1);
                end
            end
            ST_MERGE: begin
                if (ctl_q.mcnt == CW'(K)) begin
                    if (busy == '0) begin
                        ctl_d.res_v = 1'b1;
                        ctl_d.res_d = fwd[0];
                        ctl_d.st    = ST_RUN;
                        ctl_d.open  = 1'b0;
                        bank_clr    = 1'b1;
                    end
                end else if (avail[0]) begin
                    issue_v    = 1'b1;
                    issue_a    = fwd[0];
                    issue_b    = fwd[TW'(ctl_q.mcnt)];
                    issue_tag  = '0;
                    ctl_d.mcnt = ctl_q.mcnt + CW'(1);
                end
            end
            default: begin
                ctl_d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_RUN, slot: '0, open: 1'b0, op: OP_ADD,
                       mcnt: '0, res_v: 1'b0, res_d: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign res_valid = ctl_q.res_v;
    assign res_data  = ctl_q.res_d;

endmodule

// File: rtl/redu_checker.sv
module redu_checker #(
    parameter int K  = 3,
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_last,
    input logic          res_valid,
    input logic          issue_valid,
    input logic [TW-1:0] issue_tag,
    input logic [K-1:0]  busy,
    input logic          ret_valid,
    input logic [TW-1:0] ret_tag,
    input logic          pipe_empty
);

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (!res_valid && in_ready)); // R1

    AST_ISSUE_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (!busy[issue_tag] || (ret_valid && ret_tag == issue_tag))); // R4

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R7

    AST_CLOSED_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_last) |=> !in_ready); // R7

    AST_NO_BEAT_WHEN_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_last && !in_valid) |=> !issue_valid); // R9

    AST_DRAINED_BEFORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(pipe_empty)); // R8

endmodule

bind redu_top redu_checker #(.K(K), .TW(TW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_last     (in_last),
    .res_valid   (res_valid),
    .issue_valid (issue_v),
    .issue_tag   (issue_tag),
    .busy        (busy),
    .ret_valid   (ret_valid),
    .ret_tag     (ret_tag),
    .pipe_empty  (pipe_empty)
);

// File: tb/sim_redu_top.sv
module sim_redu_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         in_last = 1'b0;
    logic         in_op = 1'b0;
    logic         res_valid;
    logic [W-1:0] res_data;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] elems [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    redu_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_op     (in_op),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] model(input logic op, input int n);
        logic [W-1:0] a = op ? 1 : 0;
        for (int i = 0; i < n; i++) begin
            a = op ? a * elems[i] : a + elems[i];
        end
        return a;
    endfunction

    // send n elements; tail: end with a separate data-less marker;
    // flip: drive the opposite operation after the first beat
    task automatic run_stream(input logic op, input int n, input bit tail,
                              input bit flip, input string req, output int stalls);
        logic [W-1:0] exp;
        int wait_cnt;
        exp = model(op, n);
        stalls = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = elems[i];
            in_last  = (i == n - 1) && !tail;
            in_op    = (flip && i > 0) ? ~op : op;
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
            end
        end
        if (tail || n == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_last  = 1'b1;
            in_op    = (flip && n > 0) ? ~op : op;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_op    = op;
        chk(!in_ready, "R7 ready low after end", {31'b0, in_ready}, 0);
        wait_cnt = 0;
        while (!res_valid && wait_cnt < 200) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(res_valid, "R8 result strobe arrives", {31'b0, res_valid}, 1);
        chk(res_data == exp, req, res_data, exp);
        @(negedge clk);
        chk(!res_valid, "R7 single-cycle strobe", {31'b0, res_valid}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int st;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready, "R1 ready after reset", {31'b0, in_ready}, 1);
        chk(!res_valid, "R1 no result after reset", {31'b0, res_valid}, 0);

        // R5 empty streams
        run_stream(1'b0, 0, 1'b1, 1'b0, "R5 empty sum is 0", st);
        run_stream(1'b1, 0, 1'b1, 1'b0, "R5 empty product is 1", st);

        // R2 / R3 small lengths around K
        elems[0] = 32'd7; elems[1] = 32'd11; elems[2] = 32'd13; elems[3] = 32'd5;
        run_stream(1'b0, 1, 1'b0, 1'b0, "R2 single element sum", st);
        run_stream(1'b1, 2, 1'b0, 1'b0, "R3 two element product", st);
        run_stream(1'b1, 3, 1'b0, 1'b0, "R3 product of K elements", st);
        run_stream(1'b0, 4, 1'b0, 1'b0, "R4 leftover element K+1 sum", st);

        // R2 wrap modulo 2^W
        elems[0] = 32'hFFFF_FFF0; elems[1] = 32'h0000_0020; elems[2] = 32'h8000_0000;
        run_stream(1'b0, 3, 1'b0, 1'b0, "R2 sum wraps", st);
        elems[0] = 32'h0001_0001; elems[1] = 32'h0001_0001; elems[2] = 32'hFFFF_FFFF;
        run_stream(1'b1, 3, 1'b0, 1'b0, "R3 product truncates", st);

        // R9 data-less end marker after elements
        elems[0] = 32'd100; elems[1] = 32'd200;
        run_stream(1'b0, 2, 1'b1, 1'b0, "R9 marker adds nothing", st);

        // R6 op change mid-stream ignored
        elems[0] = 32'd3; elems[1] = 32'd4; elems[2] = 32'd5; elems[3] = 32'd6;
        run_stream(1'b1, 4, 1'b0, 1'b1, "R6 op held from first beat (mul)", st);
        run_stream(1'b0, 4, 1'b1, 1'b1, "R6 op held from first beat (add)", st);

        // R4 long back-to-back stream: full rate with K = L
        for (int i = 0; i < 40; i++) elems[i] = $urandom;
        run_stream(1'b1, 40, 1'b0, 1'b0, "R3 long product", st);
        chk(st == 0, "R4 no stall at full rate", st, 0);
        run_stream(1'b0, 40, 1'b0, 1'b0, "R9 next stream independent", st);
        chk(st == 0, "R4 no stall at full rate (sum)", st, 0);

        // random streams
        for (int r = 0; r < 24; r++) begin
            int n;
            logic op;
            bit tl, fl;
            n  = $urandom_range(0, 14);
            op = 1'($urandom_range(0, 1));
            tl = (n == 0) ? 1'b1 : 1'($urandom_range(0, 1));
            fl = 1'($urandom_range(0, 1));
            for (int i = 0; i < n; i++) elems[i] = $urandom;
            run_stream(op, n, tl, fl, op ? "R3 random product" : "R2 random sum", st);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule